// File: doc/BRIEF.md
# Virtual Channel Link Multiplexer with Receiver-Gated Arbitration

This block lets several virtual channels take turns on one shared physical link. Each channel has a sending lane, which offers a flit, and a receiving lane, which raises a readiness signal while it has room for one more flit. A channel may compete for the link only when both ends agree: the sender holds a flit and the receiver has space. A round-robin arbiter picks one eligible channel and produces a one-hot select. That one select drives two things. It picks the sending lane in the multiplexer, and it steers the receiving demultiplexer, so each flit comes out on the lane it went in on.

Each transfer runs as a short sequence. In the grant cycle the sender is acknowledged and the flit is captured. The flit is then presented to the selected output until that output accepts it. A return-to-idle cycle follows, in which no select is driven and no new grant is made. The only acknowledge in the link is the accept on the selected output. No per-channel acknowledge runs back along the readiness path. The channel count must be a power of two.

Top module: `vc_link_mux`

## Requirements
- R1: A sender lane is acknowledged (`snd_ready[i]` high) only in a cycle where both its `snd_valid[i]` and the matching `rcv_sync[i]` are high; with no such channel no acknowledge is given.
- R2: At most one bit of `snd_ready` and at most one bit of `link_sel` is high in any cycle.
- R3: The cycle after channel i is acknowledged, `link_sel` and `rcv_valid` both equal the one-hot code with only bit i set, and output lane i of `rcv_data` carries the flit taken from input lane i.
- R4: While the selected output has not accepted, `link_sel` and the delivered flit hold their values.
- R5: The cycle after the selected output accepts is a return-to-idle cycle: `link_sel` and `rcv_valid` are zero and no sender is acknowledged, even with every channel eligible.
- R6: The grant is round-robin. The search starts at the index after the last granted channel and wraps from N-1 to 0.
- R7: After reset no flit is presented, and the first search starts at channel 0.
- R8: An accept asserted on a lane that is not selected is ignored: the transfer continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snd_valid | input | NUM_VC | Sender lane i holds a flit |
| snd_data | input | NUM_VC*FLIT_W | Flit of each sender lane, lane i at bits [i*FLIT_W +: FLIT_W] |
| snd_ready | output | NUM_VC | Flit of lane i taken this cycle |
| rcv_sync | input | NUM_VC | Receiver lane i has room for a flit |
| rcv_valid | output | NUM_VC | Flit presented on receiver lane i |
| rcv_data | output | NUM_VC*FLIT_W | Flit per receiver lane, zero on unselected lanes |
| rcv_accept | input | NUM_VC | Receiver lane i takes the presented flit |
| link_sel | output | NUM_VC | One-hot channel select that steers mux and demux |

## Verification
The bench builds the block with four channels and eight-bit flits. Each flit carries its vector number and its source lane, so a delivery on the wrong lane, or out of order within a lane, shows up in the data. With four lanes the round-robin pointer can wrap, skip a lane that is not eligible, and find no eligible lane at all, all within a short table. The table mixes sender masks and receiver masks so that a lane is refused because of either side alone.

// File: rtl/vc_link_pkg.sv
package vc_link_pkg;
  typedef enum logic [1:0] {
    LNK_IDLE = 2'd0,
    LNK_XFER = 2'd1,
    LNK_RTZ  = 2'd2
  } lnk_state_e;
endpackage

// File: rtl/vc_rr_arbiter.sv
module vc_rr_arbiter #(
  parameter int NUM_VC = 4,
  localparam int IW = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [NUM_VC-1:0] req,
  output logic [NUM_VC-1:0] gnt,
  output logic              gnt_any
);
  logic [IW-1:0] last_q;

  function automatic logic [NUM_VC-1:0] rr_pick(input logic [NUM_VC-1:0] r,
                                                input logic [IW-1:0] last);
    logic [NUM_VC-1:0] g;
    logic found;
    g = '0;
    found = 1'b0;
    for (int k = 1; k <= NUM_VC; k++) begin
      int j;
      j = (int'(last) + k) % NUM_VC;
      if (!found && r[j]) begin
        g[j] = 1'b1;
        found = 1'b1;
      end
    end
    return g;
  endfunction

  function automatic logic [IW-1:0] oh_index(input logic [NUM_VC-1:0] oh);
    logic [IW-1:0] idx;
    idx = '0;
    for (int k = 0; k < NUM_VC; k++) begin
      if (oh[k]) idx = IW'(k);
    end
    return idx;
  endfunction

  assign gnt     = enable ? rr_pick(req, last_q) : '0;
  assign gnt_any = |gnt;

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= IW'(NUM_VC - 1);
    else if (gnt_any) last_q <= oh_index(gnt);
  end

  // R2
  arb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));
  // R1
  arb_req_chk: assert property (@(posedge clk) disable iff (!rst_n) ((gnt & ~req) == '0));
endmodule

// File: rtl/vc_sel_mux.sv
module vc_sel_mux #(
  parameter int NUM_VC = 4,
  parameter int FLIT_W = 8
) (
  input  logic [NUM_VC-1:0]        sel,
  input  logic [NUM_VC*FLIT_W-1:0] lanes,
  output logic [FLIT_W-1:0]        out
);
  always_comb begin
    out = '0;
    for (int i = 0; i < NUM_VC; i++) begin
      out = out | (lanes[i*FLIT_W +: FLIT_W] & {FLIT_W{sel[i]}});
    end
  end
endmodule

// File: rtl/vc_link_ctrl.sv
module vc_link_ctrl
  import vc_link_pkg::*;
#(
  parameter int NUM_VC = 4,
  parameter int FLIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_VC-1:0] gnt,
  input  logic              gnt_any,
  input  logic [FLIT_W-1:0] gnt_flit,
  input  logic [NUM_VC-1:0] rcv_accept,
  output logic [NUM_VC-1:0] sel,
  output logic [FLIT_W-1:0] link_flit,
  output logic              idle,
  output logic              accept_hit
);
  lnk_state_e state_q;

  assign idle       = (state_q == LNK_IDLE);
  assign accept_hit = (state_q == LNK_XFER) && (|(rcv_accept & sel));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= LNK_IDLE;
      sel       <= '0;
      link_flit <= '0;
    end else begin
      case (state_q)
        LNK_IDLE: if (gnt_any) begin
          state_q   <= LNK_XFER;
          sel       <= gnt;
          link_flit <= gnt_flit;
        end
        LNK_XFER: if (accept_hit) begin
          state_q <= LNK_RTZ;
          sel     <= '0;
        end
        default: state_q <= LNK_IDLE;
      endcase
    end
  end

  // R3
  ctrl_sel_follows_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_any |=> (sel == $past(gnt)));
  // R4
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == LNK_XFER) && !accept_hit) |=> ($stable(sel) && $stable(link_flit)));
  // R5
  ctrl_rtz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_hit |=> ((sel == '0) && !gnt_any));
  // R2
  ctrl_sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(sel));
endmodule

// File: rtl/vc_demux.sv
module vc_demux #(
  parameter int NUM_VC = 4,
  parameter int FLIT_W = 8
) (
  input  logic [NUM_VC-1:0]        sel,
  input  logic [FLIT_W-1:0]        flit,
  output logic [NUM_VC-1:0]        valid,
  output logic [NUM_VC*FLIT_W-1:0] lanes
);
  for (genvar i = 0; i < NUM_VC; i++) begin : g_lane
    assign valid[i]                  = sel[i];
    assign lanes[i*FLIT_W +: FLIT_W] = sel[i] ? flit : '0;
  end
endmodule

// File: rtl/vc_link_mux.sv
module vc_link_mux #(
  parameter int NUM_VC = 4,
  parameter int FLIT_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_VC-1:0]        snd_valid,
  input  logic [NUM_VC*FLIT_W-1:0] snd_data,
  output logic [NUM_VC-1:0]        snd_ready,
  input  logic [NUM_VC-1:0]        rcv_sync,
  output logic [NUM_VC-1:0]        rcv_valid,
  output logic [NUM_VC*FLIT_W-1:0] rcv_data,
  input  logic [NUM_VC-1:0]        rcv_accept,
  output logic [NUM_VC-1:0]        link_sel
);
  logic [NUM_VC-1:0] eligible;
  logic [NUM_VC-1:0] gnt;
  logic              gnt_any;
  logic              idle;
  logic              accept_hit;
  logic [FLIT_W-1:0] gnt_flit;
  logic [FLIT_W-1:0] link_flit;

  assign eligible  = snd_valid & rcv_sync;
  assign snd_ready = gnt;

  vc_rr_arbiter #(.NUM_VC(NUM_VC)) u_arb (
    .clk(clk), .rst_n(rst_n), .enable(idle), .req(eligible),
    .gnt(gnt), .gnt_any(gnt_any)
  );

  vc_sel_mux #(.NUM_VC(NUM_VC), .FLIT_W(FLIT_W)) u_mux (
    .sel(gnt), .lanes(snd_data), .out(gnt_flit)
  );

  vc_link_ctrl #(.NUM_VC(NUM_VC), .FLIT_W(FLIT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .gnt(gnt), .gnt_any(gnt_any), .gnt_flit(gnt_flit),
    .rcv_accept(rcv_accept), .sel(link_sel), .link_flit(link_flit),
    .idle(idle), .accept_hit(accept_hit)
  );

  vc_demux #(.NUM_VC(NUM_VC), .FLIT_W(FLIT_W)) u_demux (
    .sel(link_sel), .flit(link_flit), .valid(rcv_valid), .lanes(rcv_data)
  );

  // R1
  top_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((snd_ready & ~(snd_valid & rcv_sync)) == '0));
  // R2
  top_ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(snd_ready));
  // R8
  top_foreign_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((link_sel != '0) && ((rcv_accept & link_sel) == '0)) |=> $stable(link_sel));
endmodule

// File: tb/vc_link_mux_bench.sv
`timescale 1ns/1ps
module vc_link_mux_bench;
  localparam int N = 4;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   snd_valid = '0;
  logic [N*W-1:0] snd_data = '0;
  logic [N-1:0]   snd_ready;
  logic [N-1:0]   rcv_sync = '0;
  logic [N-1:0]   rcv_valid;
  logic [N*W-1:0] rcv_data;
  logic [N-1:0]   rcv_accept = '0;
  logic [N-1:0]   link_sel;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  vc_link_mux #(.NUM_VC(N), .FLIT_W(W)) u_vc_link_mux (
    .clk(clk), .rst_n(rst_n), .snd_valid(snd_valid), .snd_data(snd_data),
    .snd_ready(snd_ready), .rcv_sync(rcv_sync), .rcv_valid(rcv_valid),
    .rcv_data(rcv_data), .rcv_accept(rcv_accept), .link_sel(link_sel)
  );

  // fields: sender mask [11:8], receiver mask [7:4], expected one-hot grant [3:0]
  localparam logic [11:0] VEC [12] = '{
    12'hF_F_1, 12'hF_F_2, 12'hF_7_4, 12'hF_7_1,
    12'hA_F_2, 12'hA_F_8, 12'hC_3_0, 12'h1_1_1,
    12'h8_8_8, 12'h0_F_0, 12'hF_8_8, 12'h6_6_2
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [N*W-1:0] lane_tags(input int v);
    logic [N*W-1:0] d;
    for (int i = 0; i < N; i++) d[i*W +: W] = {4'(v), 4'(i)};
    return d;
  endfunction

  function automatic logic [N*W-1:0] expect_out(input logic [N-1:0] oh, input int v);
    logic [N*W-1:0] d;
    d = '0;
    for (int i = 0; i < N; i++) if (oh[i]) d[i*W +: W] = {4'(v), 4'(i)};
    return d;
  endfunction

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R7 reset state
    check("R7 sel in reset", 32'(link_sel), 32'h0);
    check("R7 valid in reset", 32'(rcv_valid), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 sel after reset", 32'(link_sel), 32'h0);

    for (int v = 0; v < 12; v++) begin
      logic [N-1:0] exp;
      exp = VEC[v][3:0];
      snd_valid = VEC[v][11:8];
      rcv_sync  = VEC[v][7:4];
      snd_data  = lane_tags(v);
      #1;
      // R1 R6 grant choice (R7 for the first vector)
      check($sformatf("R1/R6 grant v%0d", v), 32'(snd_ready), 32'(exp));
      @(negedge clk);
      snd_valid = '0;
      #1;
      if (exp == '0) begin
        check($sformatf("R1 no select v%0d", v), 32'(link_sel), 32'h0);
        continue;
      end
      // R3 routing
      check($sformatf("R3 sel v%0d", v), 32'(link_sel), 32'(exp));
      check($sformatf("R3 valid v%0d", v), 32'(rcv_valid), 32'(exp));
      check($sformatf("R3 data v%0d", v), rcv_data, expect_out(exp, v));
      // R8 accept on an unselected lane is ignored, R4 hold
      rcv_accept = ~exp;
      @(negedge clk);
      #1;
      check($sformatf("R8 sel held v%0d", v), 32'(link_sel), 32'(exp));
      check($sformatf("R4 data held v%0d", v), rcv_data, expect_out(exp, v));
      rcv_accept = exp;
      @(negedge clk);
      rcv_accept = '0;
      // R5 return-to-idle with every channel eligible
      snd_valid = '1;
      rcv_sync  = '1;
      #1;
      check($sformatf("R5 sel idle v%0d", v), 32'(link_sel), 32'h0);
      check($sformatf("R5 valid idle v%0d", v), 32'(rcv_valid), 32'h0);
      check($sformatf("R5 no grant v%0d", v), 32'(snd_ready), 32'h0);
      snd_valid = '0;
      rcv_sync  = '0;
      @(negedge clk);
    end

    // R2 at most one acknowledge with every lane eligible
    snd_valid = '1;
    rcv_sync  = '1;
    #1;
    check("R2 single grant", 32'($countones(snd_ready)), 32'd1);
    check("R6 wrap after ch1", 32'(snd_ready), 32'h4);
    @(negedge clk);
    snd_valid = '0;
    check("R2 single select", 32'($countones(link_sel)), 32'd1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule